// File: doc/BRIEF.md
# Multiplexed-Bus Port Expander

This block sits beside an 8051-style microcontroller whose external bus carries the low address byte and the data byte on the same eight wires. While the address-latch-enable strobe is high, the block tracks the low byte. Once the strobe falls, it holds that byte on a dedicated address output. The block also decodes the upper address lines into two memory chip selects, so the board needs no separate glue logic.

A small register window answers when the high address byte equals 0xA0. The low byte then selects a register. The register contents drive an eight-bit output port, the values and directions of six bidirectional pins, and a wake-up line. Any write of code 0xFD to the port register flips the wake-up line instead of loading the port. Bus reads return the levels of the dedicated input pins, or the state of the bidirectional pins.

All bus strobes are sampled on the block clock. The bus pins therefore change and are observed in that clock domain. The pads sit outside the block, so each tri-state pin is split into an input, an output and an output enable.

Top module: `port_expander`

## Requirements
- R1: While `rst` is high, and after it falls until the first write, `port_out` is 0x00, `wake` is 0, `pin_oe` is all zero (all bidirectional pins are inputs) and `pin_o` is all zero.
- R2: At every clock edge where `ale` is high, `lat_addr` takes the value of `ad_i`. While `ale` is low, `lat_addr` holds that value unchanged, whatever `ad_i` does.
- R3: `cs_ram` is high when address bit 15 or bit 14 (`addr_hi[7]`, `addr_hi[6]`) is high. `cs_aux` is high when bit 13 or bit 14 is high, or bit 15 is low. Both follow `addr_hi` in the same cycle.
- R4: A write is committed at the first clock edge that samples `wr_n` high after it was sampled low. The data used is the `ad_i` value of the last low cycle. The register is the one named by `lat_addr`. The new state shows right after that edge.
- R5: A write strobe has no effect when `addr_hi` is not 0xA0.
- R6: Writing the registers 0x02, 0x03, 0x04, 0x05, 0x08 and 0x09 sets the direction of bidirectional pins 0 to 5, in that order. A zero byte makes the pin an output (`pin_oe` bit high). Any non-zero byte makes it an input.
- R7: Register 0x21 holds the pin values in bits 5..0, with bit k for pin k. A pin configured as an output drives its value bit on `pin_o`.
- R8: Writing any byte other than 0xFD to register 0x40 loads it onto `port_out`. Writing 0xFF drives all eight port bits high.
- R9: Writing 0xFD to register 0x40 inverts `wake` and leaves `port_out` unchanged.
- R10: `ad_oe` is high only while `rd_n` is low and `addr_hi` is 0xA0. The read data depends on the register: 0x41 returns inputs `din[7:0]`, and 0x42 returns `din[9:8]` in bits 1..0 with zeros above. 0x21 returns, for each bidirectional pin, the external level on `pin_i` if the pin is an input, or its value bit if it is an output. Every other register reads 0x00.
- R11: Writes to registers other than those in R6, R7 and R8 change no output.
- R12: After reset, the 13-write start-up sequence sets `port_out` to 0xFF and `wake` to 0. It makes all six pins outputs, with `pin_o[5:0]` = 010111b. The sequence writes, in order, 0x01, 0x81, 0x81, 0xFF, 0xFF, 0x00, 0x00, 0x00, 0x00, 0x00, 0x00, 0xD7 and 0xFF to registers 0x81, 0x10, 0x11, 0x40, 0x41, 0x02, 0x03, 0x04, 0x05, 0x08, 0x09, 0x21 and 0x20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ale | input | 1 | Address latch enable from the controller |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| addr_hi | input | 8 | High address byte (A15..A8) |
| ad_i | input | 8 | Multiplexed address/data bus, pad input |
| ad_o | output | 8 | Read data toward the bus pad |
| ad_oe | output | 1 | Bus pad output enable |
| lat_addr | output | 8 | Latched low address byte (A7..A0) |
| cs_ram | output | 1 | Chip select for external RAM |
| cs_aux | output | 1 | Chip select for a second memory or peripheral |
| port_out | output | 8 | Eight-bit output port |
| wake | output | 1 | Wake-up line, toggled by command 0xFD |
| din | input | 10 | Dedicated input pins |
| pin_i | input | 6 | Bidirectional pins, pad input |
| pin_o | output | 6 | Bidirectional pins, value toward the pad |
| pin_oe | output | 6 | Bidirectional pins, output enable per pin |

## Verification
Chip selects and read data are combinational. The bench changes `addr_hi` or drops `rd_n` at a falling clock edge and samples 2 ns later. The latched address is due after the one rising edge that sees `ale` high. A register write is due after the first rising edge that sees `wr_n` back high. So the bench raises the strobe at a falling edge and compares port, wake and pin state at the next falling edge. A bench-side model updates these from the address and data alone. Sweeps cover all 256 high-address bytes, all 256 latched bytes and all 256 port values, including the 0xFD wake code.

// File: rtl/xp_pkg.sv
package xp_pkg;
  localparam int BUS_W = 8;
  typedef logic [BUS_W-1:0] bus_t;

  localparam bus_t REG_VAL    = 8'h21;
  localparam bus_t REG_PORT   = 8'h40;
  localparam bus_t REG_IN_LO  = 8'h41;
  localparam bus_t REG_IN_HI  = 8'h42;
  localparam bus_t WAKE_CODE  = 8'hFD;

  // register that sets the direction of bidirectional pin k
  function automatic bus_t dir_reg_addr(input int k);
    case (k)
      0:       return 8'h02;
      1:       return 8'h03;
      2:       return 8'h04;
      3:       return 8'h05;
      4:       return 8'h08;
      default: return 8'h09;
    endcase
  endfunction
endpackage

// File: rtl/xp_addr_latch.sv
module xp_addr_latch
  import xp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ale,
  input  bus_t ad_i,
  output bus_t lat_q
);
  always_ff @(posedge clk) begin
    if (rst)      lat_q <= '0;
    else if (ale) lat_q <= ad_i;
  end

  // R2
  hold_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!ale) |=> $stable(lat_q));
  // R2
  track_high_chk: assert property (@(posedge clk) disable iff (rst)
    ale |=> (lat_q == $past(ad_i)));
endmodule

// File: rtl/xp_bus_if.sv
module xp_bus_if
  import xp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_n,
  input  logic sel,
  input  bus_t ad_i,
  output logic we,
  output bus_t wdata
);
  logic wr_q;
  logic sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= 1'b1;
      sel_q <= 1'b0;
      wdata <= '0;
    end else begin
      wr_q <= wr_n;
      if (!wr_n) begin
        sel_q <= sel;
        wdata <= ad_i;
      end
    end
  end

  assign we = !wr_q && wr_n && sel_q;

  // R4
  we_single_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> !we);
endmodule

// File: rtl/xp_regs.sv
module xp_regs
  import xp_pkg::*;
#(
  parameter int NUM_BIDIR = 6,
  parameter int PORT_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  bus_t                 waddr,
  input  bus_t                 wdata,
  output logic [PORT_W-1:0]    port_q,
  output logic                 wake_q,
  output logic [NUM_BIDIR-1:0] val_q,
  output logic [NUM_BIDIR-1:0] dir_in_q
);
  logic hit_port;
  assign hit_port = we && (waddr == REG_PORT);

  always_ff @(posedge clk) begin
    if (rst) begin
      port_q <= '0;
      wake_q <= 1'b0;
    end else if (hit_port) begin
      if (wdata == WAKE_CODE) wake_q <= !wake_q;
      else                    port_q <= wdata[PORT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                             val_q <= '0;
    else if (we && (waddr == REG_VAL))   val_q <= wdata[NUM_BIDIR-1:0];
  end

  for (genvar k = 0; k < NUM_BIDIR; k++) begin : g_dir
    localparam bus_t DIR_ADDR = dir_reg_addr(k);
    always_ff @(posedge clk) begin
      if (rst)                            dir_in_q[k] <= 1'b1;
      else if (we && (waddr == DIR_ADDR)) dir_in_q[k] <= (wdata != '0);
    end
  end

  // R9
  wake_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_port && wdata == WAKE_CODE) |=> (wake_q != $past(wake_q)) && $stable(port_q));
  // R8
  port_load_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_port && wdata != WAKE_CODE) |=> (port_q == $past(wdata[PORT_W-1:0])) && $stable(wake_q));
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!we) |=> $stable(port_q) && $stable(wake_q) && $stable(val_q) && $stable(dir_in_q));
endmodule

// File: rtl/xp_chipsel.sv
module xp_chipsel
  import xp_pkg::*;
#(
  parameter bit CS0_WIDE = 1'b1
) (
  input  bus_t addr_hi,
  output logic cs_ram,
  output logic cs_aux
);
  logic a13, a14, a15;
  assign a13 = addr_hi[5];
  assign a14 = addr_hi[6];
  assign a15 = addr_hi[7];

  if (CS0_WIDE) begin : g_wide
    assign cs_ram = a15 | a14;
  end else begin : g_narrow
    assign cs_ram = a15;
  end

  assign cs_aux = a13 | a14 | !a15;
endmodule

// File: rtl/port_expander.sv
module port_expander
  import xp_pkg::*;
#(
  parameter int       NUM_BIDIR = 6,
  parameter int       NUM_IN    = 10,
  parameter int       PORT_W    = 8,
  parameter bit       CS0_WIDE  = 1'b1,
  parameter bit [7:0] WINDOW    = 8'hA0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ale,
  input  logic                 wr_n,
  input  logic                 rd_n,
  input  logic [7:0]           addr_hi,
  input  logic [7:0]           ad_i,
  output logic [7:0]           ad_o,
  output logic                 ad_oe,
  output logic [7:0]           lat_addr,
  output logic                 cs_ram,
  output logic                 cs_aux,
  output logic [PORT_W-1:0]    port_out,
  output logic                 wake,
  input  logic [NUM_IN-1:0]    din,
  input  logic [NUM_BIDIR-1:0] pin_i,
  output logic [NUM_BIDIR-1:0] pin_o,
  output logic [NUM_BIDIR-1:0] pin_oe
);
  localparam int HI_W = NUM_IN - BUS_W;

  logic                 sel;
  logic                 we;
  bus_t                 wdata;
  logic [NUM_BIDIR-1:0] val_q;
  logic [NUM_BIDIR-1:0] dir_in_q;
  bus_t                 pins_rd;
  bus_t                 in_hi;
  bus_t                 rd_data;

  assign sel = (addr_hi == WINDOW);

  xp_addr_latch u_latch (
    .clk   (clk),
    .rst   (rst),
    .ale   (ale),
    .ad_i  (ad_i),
    .lat_q (lat_addr)
  );

  xp_bus_if u_bus (
    .clk   (clk),
    .rst   (rst),
    .wr_n  (wr_n),
    .sel   (sel),
    .ad_i  (ad_i),
    .we    (we),
    .wdata (wdata)
  );

  xp_regs #(.NUM_BIDIR(NUM_BIDIR), .PORT_W(PORT_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .we       (we),
    .waddr    (lat_addr),
    .wdata    (wdata),
    .port_q   (port_out),
    .wake_q   (wake),
    .val_q    (val_q),
    .dir_in_q (dir_in_q)
  );

  xp_chipsel #(.CS0_WIDE(CS0_WIDE)) u_cs (
    .addr_hi (addr_hi),
    .cs_ram  (cs_ram),
    .cs_aux  (cs_aux)
  );

  assign pin_o  = val_q;
  assign pin_oe = ~dir_in_q;

  always_comb begin
    pins_rd = '0;
    for (int k = 0; k < NUM_BIDIR; k++)
      pins_rd[k] = dir_in_q[k] ? pin_i[k] : val_q[k];
    in_hi = '0;
    in_hi[HI_W-1:0] = din[NUM_IN-1:BUS_W];
    case (lat_addr)
      REG_VAL:   rd_data = pins_rd;
      REG_IN_LO: rd_data = din[BUS_W-1:0];
      REG_IN_HI: rd_data = in_hi;
      default:   rd_data = '0;
    endcase
  end

  assign ad_o  = rd_data;
  assign ad_oe = !rd_n && sel;

  // R10
  bus_release_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_n || !sel) |-> !ad_oe);
  // R3
  ram_sel_chk: assert property (@(posedge clk) disable iff (rst)
    addr_hi[7] |-> cs_ram);
  // R3
  aux_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (!addr_hi[7]) |-> cs_aux);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (port_out == '0) && !wake && (pin_oe == '0));
endmodule

// File: tb/port_expander_test.sv
module port_expander_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ale = 1'b0, wr_n = 1'b1, rd_n = 1'b1;
  logic [7:0] addr_hi = 8'h00, ad_i = 8'h00;
  logic [9:0] din = '0;
  logic [5:0] pin_i = '0;
  logic [7:0] ad_o, lat_addr, port_out;
  logic       ad_oe, cs_ram, cs_aux, wake;
  logic [5:0] pin_o, pin_oe;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  logic [7:0] exp_port;
  logic       exp_wake;
  logic [5:0] exp_dir_in, exp_val;

  always #10 clk = !clk;

  port_expander uut (
    .clk(clk), .rst(rst), .ale(ale), .wr_n(wr_n), .rd_n(rd_n),
    .addr_hi(addr_hi), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe),
    .lat_addr(lat_addr), .cs_ram(cs_ram), .cs_aux(cs_aux),
    .port_out(port_out), .wake(wake), .din(din),
    .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    exp_port = 8'h00; exp_wake = 1'b0; exp_dir_in = 6'h3F; exp_val = 6'h00;
  endtask

  task automatic model_write(input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] d);
    if (hi == 8'hA0) begin
      case (lo)
        8'h02: exp_dir_in[0] = (d != 0);
        8'h03: exp_dir_in[1] = (d != 0);
        8'h04: exp_dir_in[2] = (d != 0);
        8'h05: exp_dir_in[3] = (d != 0);
        8'h08: exp_dir_in[4] = (d != 0);
        8'h09: exp_dir_in[5] = (d != 0);
        8'h21: exp_val = d[5:0];
        8'h40: if (d == 8'hFD) exp_wake = !exp_wake; else exp_port = d;
        default: ;
      endcase
    end
  endtask

  task automatic check_state(input string tag);
    check(tag, {24'h0, port_out}, {24'h0, exp_port});
    check(tag, {31'h0, wake}, {31'h0, exp_wake});
    check(tag, {26'h0, pin_oe}, {26'h0, ~exp_dir_in});
    check(tag, {26'h0, pin_o & pin_oe}, {26'h0, exp_val & ~exp_dir_in});
  endtask

  task automatic latch_phase(input logic [7:0] hi, input logic [7:0] lo);
    @(negedge clk);
    addr_hi = hi; ad_i = lo; ale = 1'b1;
    @(negedge clk);
    ale = 1'b0;
  endtask

  task automatic bus_wr(input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] d);
    latch_phase(hi, lo);
    ad_i = d; wr_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    model_write(hi, lo, d);
  endtask

  task automatic bus_rd(input logic [7:0] hi, input logic [7:0] lo,
                        output logic [7:0] d, output logic oe);
    latch_phase(hi, lo);
    ad_i = 8'h00; rd_n = 1'b0;
    #2;
    d = ad_o; oe = ad_oe;
    @(negedge clk);
    rd_n = 1'b1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    model_reset();
    check_state("R1");
    rst = 1'b0;
    @(negedge clk);
    check_state("R1");
    check("R1", {26'h0, pin_o}, 32'h0);
  endtask

  initial begin
    logic [7:0] rd;
    logic       oe;
    logic [7:0] exp_rd;
    model_reset();
    do_reset();

    // R3: every high address byte
    for (int h = 0; h < 256; h++) begin
      logic [7:0] hb;
      hb = h[7:0];
      @(negedge clk);
      addr_hi = hb;
      #2;
      check("R3", {31'h0, cs_ram}, {31'h0, hb[7] | hb[6]});
      check("R3", {31'h0, cs_aux}, {31'h0, hb[5] | hb[6] | !hb[7]});
    end

    // R2: every low byte, then hold while ALE is low
    for (int v = 0; v < 256; v++) begin
      latch_phase(8'h00, v[7:0]);
      ad_i = ~v[7:0];
      @(negedge clk);
      check("R2", {24'h0, lat_addr}, {24'h0, v[7:0]});
    end

    // R12: start-up sequence
    bus_wr(8'hA0, 8'h81, 8'h01);
    bus_wr(8'hA0, 8'h10, 8'h81);
    bus_wr(8'hA0, 8'h11, 8'h81);
    bus_wr(8'hA0, 8'h40, 8'hFF);
    bus_wr(8'hA0, 8'h41, 8'hFF);
    bus_wr(8'hA0, 8'h02, 8'h00);
    bus_wr(8'hA0, 8'h03, 8'h00);
    bus_wr(8'hA0, 8'h04, 8'h00);
    bus_wr(8'hA0, 8'h05, 8'h00);
    bus_wr(8'hA0, 8'h08, 8'h00);
    bus_wr(8'hA0, 8'h09, 8'h00);
    bus_wr(8'hA0, 8'h21, 8'hD7);
    bus_wr(8'hA0, 8'h20, 8'hFF);
    check("R12", {24'h0, port_out}, 32'hFF);
    check("R12", {31'h0, wake}, 32'h0);
    check("R12", {26'h0, pin_oe}, 32'h3F);
    check("R12", {26'h0, pin_o}, 32'h17);
    check_state("R12");

    // R8 / R9 / R4: every port value, 0xFD flips wake
    for (int v = 0; v < 256; v++) begin
      bus_wr(8'hA0, 8'h40, v[7:0]);
      check_state(v == 8'hFD ? "R9" : "R8");
    end
    bus_wr(8'hA0, 8'h40, 8'hFD);
    check_state("R9");

    // R5: writes outside the window
    bus_wr(8'hA1, 8'h40, 8'h5A);
    check_state("R5");
    bus_wr(8'h20, 8'h21, 8'h3F);
    check_state("R5");

    // R11: unmapped register writes
    bus_wr(8'hA0, 8'h20, 8'h00);
    bus_wr(8'hA0, 8'h06, 8'h00);
    bus_wr(8'hA0, 8'h41, 8'h12);
    check_state("R11");

    // R6 / R7: mixed directions and values
    bus_wr(8'hA0, 8'h02, 8'h55);
    bus_wr(8'hA0, 8'h04, 8'h01);
    bus_wr(8'hA0, 8'h08, 8'h80);
    bus_wr(8'hA0, 8'h21, 8'h2C);
    check_state("R6");
    check("R6", {26'h0, pin_oe}, 32'h2A);
    check("R7", {26'h0, pin_o & pin_oe}, {26'h0, 6'h2C & 6'h2A});

    // R10: pin readback over every external pattern
    for (int p = 0; p < 64; p++) begin
      pin_i = p[5:0];
      bus_rd(8'hA0, 8'h21, rd, oe);
      exp_rd = {2'b00, (exp_dir_in & p[5:0]) | (~exp_dir_in & exp_val)};
      check("R10", {24'h0, rd}, {24'h0, exp_rd});
      check("R10", {31'h0, oe}, 32'h1);
    end

    // R10: dedicated inputs
    for (int q = 0; q < 1024; q += 37) begin
      din = q[9:0];
      bus_rd(8'hA0, 8'h41, rd, oe);
      check("R10", {24'h0, rd}, {24'h0, q[7:0]});
      bus_rd(8'hA0, 8'h42, rd, oe);
      check("R10", {24'h0, rd}, {30'h0, q[9:8]});
    end
    bus_rd(8'hA0, 8'h30, rd, oe);
    check("R10", {24'h0, rd}, 32'h0);
    bus_rd(8'hA2, 8'h41, rd, oe);
    check("R10", {31'h0, oe}, 32'h0);
    #2;
    check("R10", {31'h0, ad_oe}, 32'h0);

    // R1: reset again mid-run
    do_reset();

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule